// File: doc/BRIEF.md
# Coprocessor Context Save/Restore Responder

This block sits on the coprocessor side of a host interface and answers the host's context-switch traffic through three word registers: control, save and restore. A host reads the save register to capture the coprocessor's state. Depending on what the coprocessor is doing, the reply is a stall, a refusal, an empty-state marker, or a valid header followed by the state words. A host writes a format word to the restore register to reset the coprocessor or to load a saved frame. The block checks that format word and reports the outcome on later reads of the restore register. A write to the control register can abort whatever save or restore is half done.

Every access is a single-cycle read or write strobe. `ready_o` answers it in the next cycle, with read data on `rdata_o`. The `busy_i` input stands in for a long-running coprocessor operation. While it is high, saves are held off, and it marks the context as live. The internal state is a small array of `FRAME_WORDS` 32-bit words.

Top module: `cp_ctx_resp`

## Requirements
- R1: `ready_o` is high in exactly the cycle after a cycle with `rd_i` or `wr_i` high, and `rdata_o` holds the read result in that cycle. Register addresses are 0 = control, 1 = save and 2 = restore. Reset drives `ready_o` and `rdata_o` to 0.
- R2: Every format word carries the format code in bits 31:24, the frame length in bytes in bits 23:16, and zero in bits 15:0. Code 0x00 means empty/reset, 0x01 not-ready and 0x02 invalid. A code of 0x03 or above means a valid frame of length 4*FRAME_WORDS.
- R3: After reset, or after an empty/reset restore, and as long as `busy_i` has not been high since, a save read returns 0x00000000. The next save read returns one reserved word of 0, and the empty save is then complete.
- R4: While the context is live and no save is in progress, a save read with `busy_i` high returns the not-ready word 0x01000000 and does not start the save. The first save read with `busy_i` low returns VALID_CODE with length 4*FRAME_WORDS.
- R5: After the valid header, the next FRAME_WORDS save reads return the context words from index 0 upward. The save read after those starts a new save.
- R6: A restore write whose code is 0x03 or above and whose length is 4*FRAME_WORDS is accepted. The next FRAME_WORDS restore writes load the context words from index 0 upward, and a later save returns them.
- R7: A restore write with code 0x01 or 0x02, or with a code of 0x03 or above and a wrong length, is rejected. Later restore reads return 0x02000000, and the context and its empty or live status do not change.
- R8: A restore read after an accepted frame echoes the accepted code with length 4*FRAME_WORDS, or returns 0x01000000 while `busy_i` is high. After an empty/reset restore it returns 0x00000000.
- R9: A save read while a restore frame is still loading returns 0x02000000 and does not disturb the load.
- R10: A control write with bit 0 set ends any save in progress, so the next save read starts with a header. It also drops a partly loaded frame, leaving the empty/reset state. A control write with bit 0 clear changes nothing.
- R11: A restore write with code 0x00, whatever its length, ends any save in progress, clears the context words to 0 and enters the empty/reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 save, 2 restore |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 32 | Write data |
| busy_i | input | 1 | Long-running coprocessor operation in progress |
| ready_o | output | 1 | Access acknowledge, one cycle after the strobe |
| rdata_o | output | 32 | Read data, valid while ready_o is high |

## Verification
Several properties are checked on every cycle:
- the one-cycle acknowledge timing;
- the zero low half of restore replies;
- the not-ready stall on a busy save;
- the refusal of saves during a restore load;
- the return to idle after an abort or an empty/reset restore.

Other behaviour can only be shown by the bench's scenarios, because it depends on history:
- the reserved word that follows an empty save;
- the ordering of context words across a save;
- which status a restore read reports;
- that a rejected restore leaves the earlier context intact.

The bench covers these with a sweep over every format code at three lengths.

// File: rtl/cp_ctx_pkg.sv
`timescale 1ns/1ps
package cp_ctx_pkg;
  localparam logic [1:0] A_CTRL    = 2'd0;
  localparam logic [1:0] A_SAVE    = 2'd1;
  localparam logic [1:0] A_RESTORE = 2'd2;

  localparam logic [7:0] CODE_EMPTY       = 8'h00;
  localparam logic [7:0] CODE_NOTRDY      = 8'h01;
  localparam logic [7:0] CODE_INVALID     = 8'h02;
  localparam logic [7:0] CODE_FIRST_VALID = 8'h03;

  typedef enum logic [1:0] {M_NULL, M_LIVE, M_LOAD} mode_e;
  typedef enum logic [1:0] {SV_IDLE, SV_RSV, SV_DATA} save_ph_e;
  typedef enum logic [1:0] {RS_EMPTY, RS_VALID, RS_INVALID} rs_stat_e;
  typedef enum logic [1:0] {FK_EMPTY, FK_VALID, FK_BAD} fmt_kind_e;

  function automatic logic [31:0] fmt_word(input logic [7:0] code, input logic [7:0] len);
    return {code, len, 16'h0000};
  endfunction
endpackage

// File: rtl/cp_ctx_fmt_check.sv
`timescale 1ns/1ps
module cp_ctx_fmt_check
  import cp_ctx_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 16
) (
  input  logic [15:0] hdr_i,
  output fmt_kind_e   kind_o
);
  localparam logic [7:0] LEN = 8'(FRAME_BYTES);

  always_comb begin
    if (hdr_i[15:8] == CODE_EMPTY)
      kind_o = FK_EMPTY;
    else if (hdr_i[15:8] >= CODE_FIRST_VALID && hdr_i[7:0] == LEN)
      kind_o = FK_VALID;
    else
      kind_o = FK_BAD;
  end
endmodule

// File: rtl/cp_ctx_store.sv
`timescale 1ns/1ps
module cp_ctx_store #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [WORDS*DW-1:0] flat;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (clr_i)                         q <= '0;
      else if (we_i && widx_i == IW'(i))      q <= wdata_i;
    end
    assign flat[i*DW +: DW] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < WORDS; k++)
      if (ridx_i == IW'(k)) rdata_o = flat[k*DW +: DW];
  end
endmodule

// File: rtl/cp_ctx_resp.sv
`timescale 1ns/1ps
module cp_ctx_resp
  import cp_ctx_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 4,
  parameter logic [7:0]  VALID_CODE  = 8'h21
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  output logic        ready_o,
  output logic [31:0] rdata_o
);
  localparam int unsigned FRAME_BYTES = FRAME_WORDS * 4;
  localparam int unsigned IW          = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [IW-1:0] LAST      = IW'(FRAME_WORDS - 1);
  localparam logic [7:0]  LEN         = 8'(FRAME_BYTES);
  localparam logic [31:0] W_EMPTY     = fmt_word(CODE_EMPTY, 8'h00);
  localparam logic [31:0] W_NOTRDY    = fmt_word(CODE_NOTRDY, 8'h00);
  localparam logic [31:0] W_INVALID   = fmt_word(CODE_INVALID, 8'h00);
  localparam logic [31:0] W_VALID     = fmt_word(VALID_CODE, LEN);

  mode_e    mode_q, mode_d;
  save_ph_e sv_ph_q, sv_ph_d;
  rs_stat_e rs_stat_q, rs_stat_d;
  logic [IW-1:0] sv_idx_q, sv_idx_d, ld_idx_q, ld_idx_d;
  logic [7:0]    rs_code_q, rs_code_d;
  logic [31:0]   rd_word, st_rdata;
  logic          st_we, st_clr;
  fmt_kind_e     kind;

  cp_ctx_fmt_check #(.FRAME_BYTES(FRAME_BYTES)) u_fmt (
    .hdr_i  (wdata_i[31:16]),
    .kind_o (kind)
  );

  cp_ctx_store #(.WORDS(FRAME_WORDS), .DW(32)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_clr),
    .we_i    (st_we),
    .widx_i  (ld_idx_q),
    .wdata_i (wdata_i),
    .ridx_i  (sv_idx_q),
    .rdata_o (st_rdata)
  );

  always_comb begin
    mode_d    = mode_q;
    sv_ph_d   = sv_ph_q;
    sv_idx_d  = sv_idx_q;
    ld_idx_d  = ld_idx_q;
    rs_stat_d = rs_stat_q;
    rs_code_d = rs_code_q;
    rd_word   = '0;
    st_we     = 1'b0;
    st_clr    = 1'b0;

    // an operation running from the empty state makes the context live
    if (mode_q == M_NULL && busy_i) mode_d = M_LIVE;

    if (rd_i) begin
      unique case (addr_i)
        A_SAVE: begin
          if (mode_q == M_LOAD) begin
            rd_word = W_INVALID;
          end else begin
            unique case (sv_ph_q)
              SV_RSV: begin
                rd_word = '0;
                sv_ph_d = SV_IDLE;
              end
              SV_DATA: begin
                rd_word = st_rdata;
                if (sv_idx_q == LAST) begin
                  sv_ph_d  = SV_IDLE;
                  sv_idx_d = '0;
                end else begin
                  sv_idx_d = sv_idx_q + 1'b1;
                end
              end
              default: begin
                if (mode_q == M_NULL) begin
                  rd_word = W_EMPTY;
                  sv_ph_d = SV_RSV;
                end else if (busy_i) begin
                  rd_word = W_NOTRDY;
                end else begin
                  rd_word  = W_VALID;
                  sv_ph_d  = SV_DATA;
                  sv_idx_d = '0;
                end
              end
            endcase
          end
        end
        A_RESTORE: begin
          if (rs_stat_q == RS_INVALID)   rd_word = W_INVALID;
          else if (busy_i)               rd_word = W_NOTRDY;
          else if (rs_stat_q == RS_VALID) rd_word = fmt_word(rs_code_q, LEN);
          else                           rd_word = W_EMPTY;
        end
        default: rd_word = '0;
      endcase
    end

    if (wr_i) begin
      unique case (addr_i)
        A_CTRL: begin
          if (wdata_i[0]) begin
            sv_ph_d  = SV_IDLE;
            sv_idx_d = '0;
            if (mode_q == M_LOAD) begin
              mode_d    = M_NULL;
              ld_idx_d  = '0;
              st_clr    = 1'b1;
              rs_stat_d = RS_EMPTY;
            end
          end
        end
        A_RESTORE: begin
          sv_ph_d  = SV_IDLE;
          sv_idx_d = '0;
          if (mode_q == M_LOAD) begin
            st_we = 1'b1;
            if (ld_idx_q == LAST) begin
              mode_d   = M_LIVE;
              ld_idx_d = '0;
            end else begin
              ld_idx_d = ld_idx_q + 1'b1;
            end
          end else begin
            unique case (kind)
              FK_EMPTY: begin
                mode_d    = M_NULL;
                st_clr    = 1'b1;
                rs_stat_d = RS_EMPTY;
              end
              FK_VALID: begin
                mode_d    = M_LOAD;
                ld_idx_d  = '0;
                rs_stat_d = RS_VALID;
                rs_code_d = wdata_i[31:24];
              end
              default: rs_stat_d = RS_INVALID;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_NULL;
      sv_ph_q   <= SV_IDLE;
      sv_idx_q  <= '0;
      ld_idx_q  <= '0;
      rs_stat_q <= RS_EMPTY;
      rs_code_q <= '0;
      ready_o   <= 1'b0;
      rdata_o   <= '0;
    end else begin
      mode_q    <= mode_d;
      sv_ph_q   <= sv_ph_d;
      sv_idx_q  <= sv_idx_d;
      ld_idx_q  <= ld_idx_d;
      rs_stat_q <= rs_stat_d;
      rs_code_q <= rs_code_d;
      ready_o   <= rd_i | wr_i;
      rdata_o   <= rd_word;
    end
  end
endmodule

// File: rtl/cp_ctx_resp_chk.sv
`timescale 1ns/1ps
module cp_ctx_resp_chk
  import cp_ctx_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  addr_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [7:0]  hdr_code_i,
  input logic        abort_i,
  input logic        busy_i,
  input logic        ready_o,
  input logic [31:0] rdata_o,
  input mode_e       mode_q,
  input save_ph_e    sv_ph_q
);
  AST_READY_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |=> ready_o); // R1
  AST_NO_SPURIOUS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> !ready_o); // R1
  AST_FMT_LOW_HALF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == A_RESTORE) |=> (rdata_o[15:0] == 16'h0000)); // R2
  AST_SAVE_STALLS_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == A_SAVE && busy_i && mode_q == M_LIVE && sv_ph_q == SV_IDLE)
    |=> (rdata_o == 32'h0100_0000 && sv_ph_q == SV_IDLE)); // R4
  AST_SAVE_REFUSED_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == A_SAVE && mode_q == M_LOAD) |=> (rdata_o == 32'h0200_0000)); // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTRL && abort_i) |=> (sv_ph_q == SV_IDLE && mode_q != M_LOAD)); // R10
  AST_EMPTY_RESTORE_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_RESTORE && mode_q != M_LOAD && hdr_code_i == 8'h00)
    |=> (mode_q == M_NULL && sv_ph_q == SV_IDLE)); // R11
endmodule

bind cp_ctx_resp cp_ctx_resp_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .hdr_code_i (wdata_i[31:24]),
  .abort_i    (wdata_i[0]),
  .busy_i     (busy_i),
  .ready_o    (ready_o),
  .rdata_o    (rdata_o),
  .mode_q     (mode_q),
  .sv_ph_q    (sv_ph_q)
);

// File: tb/tb_cp_ctx_resp.sv
`timescale 1ns/1ps
module tb_cp_ctx_resp;
  localparam int unsigned FW = 4;
  localparam logic [7:0]  VC = 8'h21;
  localparam logic [7:0]  FB = 8'(FW * 4);
  localparam logic [1:0]  AC = 2'd0, AS = 2'd1, AR = 2'd2;
  localparam logic [31:0] W_NR  = 32'h0100_0000;
  localparam logic [31:0] W_INV = 32'h0200_0000;
  localparam logic [31:0] W_VAL = {VC, FB, 16'h0000};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [31:0] wdata = '0;
  logic ready;
  logic [31:0] rdata;

  int vectors = 0, miscompares = 0;
  logic model_null;
  logic [31:0] model_ctx [FW];

  always #4 clk = ~clk;

  cp_ctx_resp #(.FRAME_WORDS(FW), .VALID_CODE(VC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .busy_i(busy), .ready_o(ready), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    chk("R1", {31'b0, ready}, 32'd0);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R1", {31'b0, ready}, 32'd1);
    d = rdata;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    chk("R1", {31'b0, ready}, 32'd0);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R1", {31'b0, ready}, 32'd1);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic expect_save(input string req);
    if (model_null) begin
      rd_chk(AS, 32'h0, req);
      rd_chk(AS, 32'h0, req);
    end else begin
      rd_chk(AS, W_VAL, req);
      for (int k = 0; k < FW; k++) rd_chk(AS, model_ctx[k], req);
    end
  endtask

  task automatic busy_pulse();
    @(negedge clk); busy = 1'b1;
    @(negedge clk);
    @(negedge clk); busy = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int c, input int li, input int k);
    return 32'h9E37_79B9 * 32'(c * 3 + li + 1) + 32'(k) * 32'h0101_0101;
  endfunction

  task automatic load_frame(input logic [7:0] code, input int seed);
    bus_wr(AR, {code, FB, 16'h0000});
    for (int k = 0; k < FW; k++) begin
      bus_wr(AR, pat(seed, 1, k));
      model_ctx[k] = pat(seed, 1, k);
    end
    model_null = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_null = 1'b1;
    for (int k = 0; k < FW; k++) model_ctx[k] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, ready}, 32'd0);
    chk("R1", rdata, 32'd0);

    // R3: empty save out of reset, twice
    rd_chk(AS, 32'h0, "R3"); rd_chk(AS, 32'h0, "R3");
    rd_chk(AS, 32'h0, "R3"); rd_chk(AS, 32'h0, "R3");

    // R4/R5: live context, busy stall then full save
    busy_pulse();
    @(negedge clk); busy = 1'b1;
    rd_chk(AS, W_NR, "R4"); rd_chk(AS, W_NR, "R4");
    @(negedge clk); busy = 1'b0;
    rd_chk(AS, W_VAL, "R2");
    for (int k = 0; k < FW; k++) rd_chk(AS, 32'h0, "R5");
    rd_chk(AS, W_VAL, "R5");
    // R10: abort restarts the save; bit 0 clear does nothing
    bus_wr(AC, 32'h0000_0001);
    rd_chk(AS, W_VAL, "R10");
    bus_wr(AC, 32'hFFFF_FFFE);
    for (int k = 0; k < FW; k++) rd_chk(AS, 32'h0, "R10");
    model_null = 1'b0;

    // sweep every code at three lengths
    for (int c = 0; c < 256; c++) begin
      for (int li = 0; li < 3; li++) begin
        logic [7:0] len;
        len = (li == 0) ? FB : (li == 1) ? FB + 8'd4 : 8'd0;
        bus_wr(AR, {8'(c), len, 16'h0000});
        if (c == 0) begin
          rd_chk(AR, 32'h0, "R8");
          model_null = 1'b1;
          for (int k = 0; k < FW; k++) model_ctx[k] = '0;
          expect_save("R11");
        end else if (c >= 3 && li == 0) begin
          rd_chk(AS, W_INV, "R9");
          for (int k = 0; k < FW; k++) begin
            bus_wr(AR, pat(c, li, k));
            model_ctx[k] = pat(c, li, k);
          end
          model_null = 1'b0;
          rd_chk(AR, {8'(c), FB, 16'h0000}, "R2");
          expect_save("R6");
        end else begin
          rd_chk(AR, W_INV, "R7");
          expect_save("R7");
        end
      end
    end

    // R8: not-ready on restore read while busy
    load_frame(8'h40, 900);
    @(negedge clk); busy = 1'b1;
    rd_chk(AR, W_NR, "R8");
    @(negedge clk); busy = 1'b0;
    rd_chk(AR, {8'h40, FB, 16'h0000}, "R8");
    expect_save("R6");

    // R10: abort during a partial load leaves the empty state
    bus_wr(AR, {8'h55, FB, 16'h0000});
    bus_wr(AR, 32'hDEAD_BEEF);
    bus_wr(AC, 32'h0000_0001);
    model_null = 1'b1;
    for (int k = 0; k < FW; k++) model_ctx[k] = '0;
    rd_chk(AR, 32'h0, "R10");
    expect_save("R10");

    // R11: empty restore ends a save in progress
    busy_pulse();
    rd_chk(AS, W_VAL, "R11");
    bus_wr(AR, 32'h0000_0000);
    rd_chk(AS, 32'h0, "R11");
    rd_chk(AS, 32'h0, "R11");
    // R11: empty restore with odd length clears loaded words
    load_frame(8'h77, 901);
    bus_wr(AR, 32'h00AB_0000);
    busy_pulse();
    rd_chk(AS, W_VAL, "R11");
    for (int k = 0; k < FW; k++) rd_chk(AS, 32'h0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule